// File: doc/BRIEF.md
# Multiplexed LED Matrix Row Scanner

The scanner refreshes an 8-row by 128-column LED matrix one row at a time. An internal frame buffer keeps every pixel. For each row the scanner first copies the row into a small staging array, arranged so that one byte holds the same bit position of every lane. It then clocks that array out over eight parallel data pins. Each data pin feeds a chain of two cascaded 8-bit external shift registers, so 16 clock pulses load all 128 columns. A latch pulse moves the loaded bits to the register outputs. The same eight pins then turn around and drive the one-hot select pattern of the row being shown.

A PWM output gates the LED drivers. It is held low while data is shifted and latched. During the row's dwell window it is high for a programmable number of system clocks. After the last row the scan returns to row 0 and signals the end of the frame with a single-cycle pulse. A host updates pixels through a simple write port that takes 16 columns per write.

Top module: `led_row_scanner`

## Requirements
- R1: While rst_n is low, and in the cycle that follows its release, pin_out, shift_clk, latch, pwm_en and frame_done are all 0.
- R2: Each row is loaded with exactly 16 rising edges of shift_clk. Each shift clock period lasts SCLK_DIV system clocks, and shift_clk is high for SCLK_DIV/2 of them (SCLK_DIV defaults to 4).
- R3: On the k-th rising edge of shift_clk within a row (k = 0..15), pin_out[j] equals the frame-buffer bit of that row at column 16*j + 15 - k. The farthest register of each cascade therefore receives its bits first.
- R4: pin_out changes only while shift_clk is low. It is stable for as long as shift_clk stays high.
- R5: After the 16th shift pulse, latch is high for exactly one system clock while shift_clk is low and pin_out is 0.
- R6: pwm_en is 0 in the load, shift and latch phases.
- R7: In the dwell window that follows each latch, pin_out equals 1 << r, where r is the row just loaded. Rows run 0,1,...,7 and then wrap to 0.
- R8: The dwell window lasts max(dwell_len, 1) system clocks. pwm_en is high in the first min(pwm_cmp, max(dwell_len, 1)) of them and low in the rest.
- R9: frame_done is a one-cycle pulse. It rises in the load cycle of row 0 that follows the dwell of row 7, so exactly 8 latch pulses occur between two pulses.
- R10: A write with fb_wr_en high stores fb_wr_data into row fb_wr_row, lane fb_wr_lane, with bit i at column 16*fb_wr_lane + i. A write that lands on the same clock edge at which that row is captured does not alter the row being loaded. The new value appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_wr_en | input | 1 | Frame-buffer write strobe |
| fb_wr_row | input | 3 | Row written |
| fb_wr_lane | input | 3 | Lane (16-column group) written |
| fb_wr_data | input | 16 | Column bits for the lane, bit i is column 16*lane+i |
| dwell_len | input | 16 | Dwell window length in system clocks (0 acts as 1) |
| pwm_cmp | input | 16 | Number of lit clocks at the start of each dwell |
| pin_out | output | 8 | Shared pins: serial data while shifting, row select while dwelling |
| shift_clk | output | 1 | Common shift clock of all chains |
| latch | output | 1 | Transfer pulse for the shift-register outputs |
| pwm_en | output | 1 | Display enable (1 = lit) |
| frame_done | output | 1 | One-cycle pulse at each wrap to row 0 |

## Verification
Two functions can fall on the same clock edge: a host write to the frame buffer, and the capture of that same row into the staging array. The bench waits for the frame_done pulse, which marks the load cycle of row 0, and in that cycle issues a write to row 0. The write therefore lands on the capture edge. The row shifted out in that frame must still carry the old bits, and the following frame must carry the new ones. Both outcomes are judged from the bits collected at the shift clock edges.

// File: rtl/lrs_pkg.sv
// Package: shared types of the LED row scanner.
// Assumes: one scan engine per matrix; the phases below run in order.
package lrs_pkg;
    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_LATCH = 2'd2,
        PH_DWELL = 2'd3
    } scan_phase_t;
endpackage

// File: rtl/lrs_frame_buffer.sv
// Frame buffer: ROWS x LANES words of CHAIN bits, one write port and one
// combinational whole-row read port.
// Assumes: a write and a read of the same row on one edge return the old data.
module lrs_frame_buffer #(
    parameter int ROWS  = 8,
    parameter int LANES = 8,
    parameter int CHAIN = 16,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ROW_W-1:0]         wr_row,
    input  logic [LANE_W-1:0]        wr_lane,
    input  logic [CHAIN-1:0]         wr_data,
    input  logic [ROW_W-1:0]         rd_row,
    output logic [LANES*CHAIN-1:0]   rd_bits
);
    logic [CHAIN-1:0] mem [ROWS][LANES];

    // Storage update: clear on reset, otherwise take one lane word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int l = 0; l < LANES; l++)
                    mem[r][l] <= '0;
        end else if (wr_en) begin
            mem[wr_row][wr_lane] <= wr_data;
        end
    end

    // Row read: concatenate all lanes of the selected row, lane 0 lowest.
    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_bits[l*CHAIN +: CHAIN] = mem[rd_row][l];
    end
endmodule

// File: rtl/lrs_transposer.sv
// Transposer: captures one row and re-orders it so that byte k holds bit
// (CHAIN-1-k) of every lane, the order in which the chains are fed.
// Assumes: capture is a single-cycle strobe; the output byte is selected by index.
module lrs_transposer #(
    parameter int LANES = 8,
    parameter int CHAIN = 16,
    localparam int BIT_W = $clog2(CHAIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [LANES*CHAIN-1:0] row_bits,
    input  logic [BIT_W-1:0]       bit_idx,
    output logic [LANES-1:0]       lane_byte
);
    logic [CHAIN-1:0][LANES-1:0] stage;

    // Staging array update: byte k gets the k-th bit to leave each lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (capture) begin
            for (int k = 0; k < CHAIN; k++)
                for (int j = 0; j < LANES; j++)
                    stage[k][j] <= row_bits[j*CHAIN + (CHAIN-1-k)];
        end
    end

    assign lane_byte = stage[bit_idx];
endmodule

// File: rtl/lrs_bit_timer.sv
// Bit timer: generates the divided shift clock and the bit index during a row
// transfer; raises last in the final system clock of the final bit.
// Assumes: DIV is even and at least 2; en stays high for the whole transfer.
module lrs_bit_timer #(
    parameter int CHAIN = 16,
    parameter int DIV   = 4,
    localparam int BIT_W = $clog2(CHAIN),
    localparam int PH_W  = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [BIT_W-1:0] bit_idx,
    output logic             sclk,
    output logic             last
);
    logic [PH_W-1:0] ph;
    logic            ph_end;

    assign ph_end = (ph == PH_W'(DIV-1));

    // Phase and bit counters: cleared while idle, advance while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph      <= '0;
            bit_idx <= '0;
        end else if (ph_end) begin
            ph      <= '0;
            bit_idx <= bit_idx + BIT_W'(1);
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    assign sclk = en && (ph >= PH_W'(DIV/2));
    assign last = en && ph_end && (bit_idx == BIT_W'(CHAIN-1));
endmodule

// File: rtl/lrs_dwell_timer.sv
// Dwell timer: counts the display window of one row and forms the PWM gate
// from a compare value.
// Assumes: a length of 0 is treated as 1; settings are held during a window.
module lrs_dwell_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DWELL_W-1:0] len,
    input  logic [DWELL_W-1:0] cmp,
    output logic               pwm,
    output logic               done
);
    logic [DWELL_W-1:0] cnt;
    logic [DWELL_W-1:0] len_eff;

    assign len_eff = (len == '0) ? DWELL_W'(1) : len;

    // Window counter: restarts at 0 for each window, runs while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else
            cnt <= cnt + DWELL_W'(1);
    end

    assign done = en && (cnt >= len_eff - DWELL_W'(1));
    assign pwm  = en && (cnt < cmp);
endmodule

// File: rtl/led_row_scanner.sv
// LED row scanner top: sequences load, shift, latch and dwell for each row,
// owns the row counter and frame pulse, and multiplexes the shared pins
// between serial data and row select.
// Assumes: ROWS equals LANES, so the one-hot row select fits on the data pins.
module led_row_scanner #(
    parameter int LANES    = 8,
    parameter int CHAIN    = 16,
    parameter int SCLK_DIV = 4,
    parameter int DWELL_W  = 16,
    localparam int ROWS   = LANES,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int LANE_W = $clog2(LANES),
    localparam int BIT_W  = $clog2(CHAIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fb_wr_en,
    input  logic [ROW_W-1:0]   fb_wr_row,
    input  logic [LANE_W-1:0]  fb_wr_lane,
    input  logic [CHAIN-1:0]   fb_wr_data,
    input  logic [DWELL_W-1:0] dwell_len,
    input  logic [DWELL_W-1:0] pwm_cmp,
    output logic [LANES-1:0]   pin_out,
    output logic               shift_clk,
    output logic               latch,
    output logic               pwm_en,
    output logic               frame_done
);
    import lrs_pkg::*;

    scan_phase_t            phase;
    logic [ROW_W-1:0]       row;
    logic [LANES*CHAIN-1:0] row_bits;
    logic [LANES-1:0]       lane_byte;
    logic [BIT_W-1:0]       bit_idx;
    logic                   sclk_raw;
    logic                   shift_last;
    logic                   dwell_pwm;
    logic                   dwell_done;
    logic                   in_shift;
    logic                   in_dwell;

    assign in_shift = (phase == PH_SHIFT);
    assign in_dwell = (phase == PH_DWELL);

    lrs_frame_buffer #(.ROWS(ROWS), .LANES(LANES), .CHAIN(CHAIN)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fb_wr_en),
        .wr_row  (fb_wr_row),
        .wr_lane (fb_wr_lane),
        .wr_data (fb_wr_data),
        .rd_row  (row),
        .rd_bits (row_bits)
    );

    lrs_transposer #(.LANES(LANES), .CHAIN(CHAIN)) u_tp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (phase == PH_LOAD),
        .row_bits  (row_bits),
        .bit_idx   (bit_idx),
        .lane_byte (lane_byte)
    );

    lrs_bit_timer #(.CHAIN(CHAIN), .DIV(SCLK_DIV)) u_bt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_shift),
        .bit_idx (bit_idx),
        .sclk    (sclk_raw),
        .last    (shift_last)
    );

    lrs_dwell_timer #(.DWELL_W(DWELL_W)) u_dt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_dwell),
        .len   (dwell_len),
        .cmp   (pwm_cmp),
        .pwm   (dwell_pwm),
        .done  (dwell_done)
    );

    // Phase sequencer, row counter and frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_LOAD;
            row        <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (phase)
                PH_LOAD:  phase <= PH_SHIFT;
                PH_SHIFT: if (shift_last) phase <= PH_LATCH;
                PH_LATCH: phase <= PH_DWELL;
                PH_DWELL: begin
                    if (dwell_done) begin
                        phase <= PH_LOAD;
                        if (row == ROW_W'(ROWS-1)) begin
                            row        <= '0;
                            frame_done <= 1'b1;
                        end else begin
                            row <= row + ROW_W'(1);
                        end
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // Shared pin multiplexer: data while shifting, row select while dwelling.
    always_comb begin
        pin_out = '0;
        if (in_shift)
            pin_out = lane_byte;
        else if (in_dwell)
            pin_out = LANES'(1) << row;
    end

    assign shift_clk = sclk_raw;
    assign latch     = (phase == PH_LATCH);
    assign pwm_en    = dwell_pwm;
endmodule

// File: rtl/lrs_checker.sv
// Checker: timing properties of the scanner's outputs, bound to the top.
// Assumes: only top-level ports are observed.
module lrs_checker #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] pin_out,
    input logic             shift_clk,
    input logic             latch,
    input logic             pwm_en,
    input logic             frame_done
);
    // R4: data pins hold still while the shift clock is high
    assert_pins_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_clk && $past(shift_clk)) |-> $stable(pin_out));

    // R5: latch is a single cycle with the shift clock low and the pins idle
    assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> !latch);
    assert_latch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> (!shift_clk && pin_out == '0));

    // R6: display blanked while shifting and latching
    assert_blank_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_clk || latch) |-> !pwm_en);

    // R7: while lit, exactly one row line is driven
    assert_row_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |-> ($countones(pin_out) == 1));

    // R9: frame pulse lasts one cycle
    assert_frame_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind led_row_scanner lrs_checker #(.LANES(LANES)) u_lrs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_out    (pin_out),
    .shift_clk  (shift_clk),
    .latch      (latch),
    .pwm_en     (pwm_en),
    .frame_done (frame_done)
);

// File: tb/tb_led_row_scanner.sv
module tb_led_row_scanner;
    localparam int DIV = 4;

    typedef struct packed {
        logic [2:0]   row;
        logic [127:0] bits;
        logic [15:0]  pwm_exp;
        logic [15:0]  len_exp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fb_wr_en = 1'b0;
    logic [2:0]  fb_wr_row = '0;
    logic [2:0]  fb_wr_lane = '0;
    logic [15:0] fb_wr_data = '0;
    logic [15:0] dwell_len = 16'd20;
    logic [15:0] pwm_cmp = 16'd5;
    logic [7:0]  pin_out;
    logic        shift_clk, latch, pwm_en, frame_done;

    int tests = 0;
    int fails = 0;
    exp_t q[$];
    logic [15:0] model [8][8];
    bit done_flag = 0;

    always #2 clk = ~clk;

    led_row_scanner dut (
        .clk(clk), .rst_n(rst_n), .fb_wr_en(fb_wr_en), .fb_wr_row(fb_wr_row),
        .fb_wr_lane(fb_wr_lane), .fb_wr_data(fb_wr_data), .dwell_len(dwell_len),
        .pwm_cmp(pwm_cmp), .pin_out(pin_out), .shift_clk(shift_clk),
        .latch(latch), .pwm_en(pwm_en), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver side: one write through the port, model updated alongside.
    task automatic wr(input int r, input int l, input logic [15:0] d);
        fb_wr_en = 1'b1; fb_wr_row = 3'(r); fb_wr_lane = 3'(l); fb_wr_data = d;
        model[r][l] = d;
        @(negedge clk);
        fb_wr_en = 1'b0;
    endtask

    task automatic wait_fd();
        @(negedge clk);
        while (!frame_done) @(negedge clk);
    endtask

    // Driver side: push the expected rows of one frame (R3, R7, R8).
    task automatic push_frame();
        int eff;
        int pe;
        eff = (dwell_len == 0) ? 1 : int'(dwell_len);
        pe  = (int'(pwm_cmp) < eff) ? int'(pwm_cmp) : eff;
        for (int r = 0; r < 8; r++) begin
            exp_t e;
            e.row = 3'(r);
            for (int c = 0; c < 8; c++)
                e.bits[16*c +: 16] = model[r][c];
            e.pwm_exp = 16'(pe);
            e.len_exp = 16'(eff);
            q.push_back(e);
        end
    endtask

    // Monitor: collects shifted bits, checks latch, dwell, pwm and frame pulse.
    logic [7:0]   cap [16];
    int           rises = 0, hi_run = 0, rows_since_fd = 0;
    bit           prev_sclk = 0, in_dw = 0, have = 0;
    exp_t         cur;
    int           dw_len = 0, pw_cnt = 0;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (shift_clk && !prev_sclk) begin
                if (rises < 16) cap[rises] = pin_out;
                rises++;
            end
            if (shift_clk) hi_run++;
            if (!shift_clk && prev_sclk) begin
                check(hi_run == DIV/2, "R2 shift clock high time", 128'(hi_run), 128'(DIV/2));
                hi_run = 0;
            end
            if (latch) begin
                check(rises == 16, "R2 shift pulses per row", 128'(rises), 128'd16);
                check(pin_out == 8'h00 && !shift_clk, "R5 latch quiet", 128'(pin_out), 128'd0);
                rows_since_fd++;
                if (q.size() > 0) begin
                    logic [127:0] act;
                    cur = q.pop_front();
                    have = 1;
                    act = '0;
                    for (int k = 0; k < 16; k++)
                        for (int j = 0; j < 8; j++)
                            act[16*j + 15 - k] = cap[k][j];
                    check(act == cur.bits, "R3 R10 row data", act, cur.bits);
                end else begin
                    have = 0;
                end
                rises = 0; in_dw = 1; dw_len = 0; pw_cnt = 0;
            end else if (in_dw) begin
                if (pin_out == 8'h00) begin
                    in_dw = 0;
                    if (have) begin
                        check(dw_len == int'(cur.len_exp), "R8 dwell length", 128'(dw_len), 128'(cur.len_exp));
                        check(pw_cnt == int'(cur.pwm_exp), "R8 pwm lit count", 128'(pw_cnt), 128'(cur.pwm_exp));
                    end
                end else begin
                    dw_len++;
                    if (pwm_en) begin
                        if (pw_cnt != dw_len - 1)
                            check(0, "R8 pwm not leading", 128'(dw_len), 128'(pw_cnt + 1));
                        pw_cnt++;
                    end
                    if (have && dw_len == 1)
                        check(pin_out == (8'h01 << cur.row), "R7 row select", 128'(pin_out),
                              128'(8'h01 << cur.row));
                end
            end
            if ((shift_clk || latch) && pwm_en)
                check(0, "R6 blank outside dwell", 128'(pwm_en), 128'd0);
            if (frame_done) begin
                check(rows_since_fd == 8, "R9 rows per frame", 128'(rows_since_fd), 128'd8);
                rows_since_fd = 0;
            end
            prev_sclk = shift_clk;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            check(0, "watchdog", 128'd0, 128'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                model[r][c] = '0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(pin_out == 0, "R1 pins in reset", 128'(pin_out), 128'd0);
        check({shift_clk, latch, pwm_en, frame_done} == 4'b0, "R1 controls in reset",
              128'({shift_clk, latch, pwm_en, frame_done}), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({pin_out, shift_clk, latch, pwm_en, frame_done} == 12'b0, "R1 first cycle",
              128'({pin_out, shift_clk, latch, pwm_en, frame_done}), 128'd0);

        // Pattern A: mixed values in every lane (R10 write mapping, R3)
        wait_fd();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                wr(r, c, 16'hA5C3 ^ 16'(r*4099 + c*257 + 17));
        wait_fd();
        push_frame();

        // Pattern B: a single bit per row, walking position; zero dwell, pwm off (R8)
        wait_fd();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                wr(r, c, (c == r) ? 16'(1 << (2*r + 1)) : 16'h0000);
        dwell_len = 16'd0; pwm_cmp = 16'd0;
        wait_fd();
        push_frame();

        // Pattern C: all ones; compare beyond window, always lit (R8)
        wait_fd();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                wr(r, c, 16'hFFFF);
        dwell_len = 16'd12; pwm_cmp = 16'd30;
        wait_fd();
        push_frame();

        // Collision: write row 0 on its capture edge (R10)
        wait_fd();
        wr(0, 0, 16'h1234);
        dwell_len = 16'd9; pwm_cmp = 16'd4;
        wait_fd();
        push_frame();
        wr(0, 0, 16'hBEEF);
        wait_fd();
        push_frame();
        wait_fd();
        check(q.size() == 0, "R7 all rows consumed", 128'(q.size()), 128'd0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule